// File: doc/BRIEF.md
# Frame Buffer Write Address Generator

This block turns a strobed byte stream from a disc front-end into write addresses for a circular frame buffer in RAM. Each byte comes with a 3-bit type code. There are four in-frame regions (main data, Q-channel, sub-channel and error flags) plus a single status byte. The block keeps a relative frame counter and one offset counter per region. The RAM address is the frame number concatenated with the in-frame offset, so each frame sits in its own 4-kbyte slot.

The front-end cannot be stalled. Every valid strobe becomes a RAM write in the same cycle. The status byte also marks the end of the frame: the offsets return to their region bases and the frame counter moves on. When the frame equal to the programmed limit completes, the counter wraps to a programmed start frame. A repeat mode holds the frame counter for a programmed number of frame ends. A host write port loads the start frame, the limit, the control bits and the repeat count, preloads the main-data offset for test, and clears the sticky overflow interrupt.

Top module: `fb_wr_addr_gen`

## Requirements
- R1: When `wr_stb` is high with a valid code, `ram_we` is high in the same cycle. `ram_wdata` equals `wr_data`, and `ram_addr` is {frame[10:0], offset[11:0]}. There is no stall output.
- R2: The type codes map as follows. Code 0 is main data at offsets 0x000..0x92F. Code 1 is Q-channel at 0x930..0x93F. Code 2 is sub-channel at 0x940..0x99F. Code 3 is error flags at 0x9A0..0xAC5. Code 4 is the status byte at 0xBDE. Codes 5..7 produce no write and change no counter.
- R3: Each region offset advances by one after each write of its type. The Q, sub and error offsets stop at the last byte of their region.
- R4: The main offset advances after each main write and stops at 0x92F. A main write that arrives after the byte at 0x92F has been written sets `ovf_irq`. The flag stays set until a host write of 1 to bit 0 at host address 5. A new overflow in the same cycle wins over the clear.
- R5: A code-4 write ends the frame. From the next cycle, every offset is back at its region base and the frame number is one higher.
- R6: When the frame number equals the limit (host address 1) at frame end, the next frame number is the start frame (host address 0).
- R7: A write to host address 0 loads the frame counter on the next cycle when control bit 0 (write block) is clear. When that bit is set, the value is only stored for the next wrap.
- R8: A write to host address 2 loads the main offset, clamped to 0x92F, and clears the overflow progress.
- R9: When control bit 1 (host address 3) is set and the repeat count (host address 4) is nonzero, a frame end decrements the count and keeps the frame number. The offsets still return to their bases.
- R10: `qs_clr` returns only the Q and sub offsets to their bases. `fe_clr` clears the frame counter and all offsets. Hardware reset clears the counters, the registers and `ovf_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | Byte strobe from the front-end |
| wr_type | input | 3 | Type code of the byte |
| wr_data | input | 8 | Data byte |
| host_we | input | 1 | Host register write |
| host_addr | input | 3 | Host register select |
| host_wdata | input | 12 | Host write data |
| qs_clr | input | 1 | Clear Q and sub-channel offsets |
| fe_clr | input | 1 | Clear frame counter and offsets |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 23 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ovf_irq | output | 1 | Sticky main-data overflow interrupt |

## Verification
The assertions check on every cycle that:
- the main offset never leaves its region;
- Q-channel addresses stay inside their window;
- the interrupt is sticky;
- a frame end clears the main offset;
- repeat mode holds the frame number;
- a wrap at the limit lands on the start frame.

Other behaviours only appear in the bench's scenarios, which are compared against a cycle model:
- the exact address sequence across frames;
- the write-block deferral of a start-frame load;
- the clamped preload;
- the selective reset of the Q and sub offsets;
- ignored type codes.

// File: rtl/fb_wr_addr_gen.sv
module fb_wr_addr_gen #(
  parameter int FRM_W  = 11,
  parameter int OFF_W  = 12,
  parameter int RCNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [2:0]             wr_type,
  input  logic [7:0]             wr_data,
  input  logic                   host_we,
  input  logic [2:0]             host_addr,
  input  logic [OFF_W-1:0]       host_wdata,
  input  logic                   qs_clr,
  input  logic                   fe_clr,
  output logic                   ram_we,
  output logic [FRM_W+OFF_W-1:0] ram_addr,
  output logic [7:0]             ram_wdata,
  output logic                   ovf_irq
);
  localparam logic [OFF_W-1:0] MAIN_LAST = 12'h92F;
  localparam logic [OFF_W-1:0] Q_BASE    = 12'h930;
  localparam logic [OFF_W-1:0] Q_LAST    = 12'h93F;
  localparam logic [OFF_W-1:0] S_BASE    = 12'h940;
  localparam logic [OFF_W-1:0] S_LAST    = 12'h99F;
  localparam logic [OFF_W-1:0] E_BASE    = 12'h9A0;
  localparam logic [OFF_W-1:0] E_LAST    = 12'hAC5;
  localparam logic [OFF_W-1:0] ST_ADDR   = 12'hBDE;

  logic [FRM_W-1:0]  frm, start_frm, last_frm;
  logic [OFF_W-1:0]  main_off, q_off, s_off, e_off, off_sel;
  logic [RCNT_W-1:0] rep_cnt;
  logic              wblk, rep_en, full;

  wire w_main = wr_stb && wr_type == 3'd0;
  wire w_q    = wr_stb && wr_type == 3'd1;
  wire w_s    = wr_stb && wr_type == 3'd2;
  wire w_e    = wr_stb && wr_type == 3'd3;
  wire eof    = wr_stb && wr_type == 3'd4;
  wire h_start = host_we && host_addr == 3'd0;
  wire h_last  = host_we && host_addr == 3'd1;
  wire h_pre   = host_we && host_addr == 3'd2;
  wire h_ctrl  = host_we && host_addr == 3'd3;
  wire h_rep   = host_we && host_addr == 3'd4;
  wire h_iclr  = host_we && host_addr == 3'd5 && host_wdata[0];
  wire hold    = rep_en && rep_cnt != '0;
  wire ovf_set = w_main && full;

  always_comb begin
    case (wr_type)
      3'd0:    off_sel = main_off;
      3'd1:    off_sel = q_off;
      3'd2:    off_sel = s_off;
      3'd3:    off_sel = e_off;
      default: off_sel = ST_ADDR;
    endcase
  end

  assign ram_we    = wr_stb && wr_type <= 3'd4;
  assign ram_addr  = {frm, off_sel};
  assign ram_wdata = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_frm <= '0;
      last_frm  <= '0;
      wblk      <= 1'b0;
      rep_en    <= 1'b0;
      rep_cnt   <= '0;
      ovf_irq   <= 1'b0;
    end else begin
      if (h_start) start_frm <= host_wdata[FRM_W-1:0];
      if (h_last)  last_frm  <= host_wdata[FRM_W-1:0];
      if (h_ctrl)  {rep_en, wblk} <= host_wdata[1:0];
      if (h_rep)             rep_cnt <= host_wdata[RCNT_W-1:0];
      else if (eof && hold)  rep_cnt <= rep_cnt - 1'b1;
      if (ovf_set)     ovf_irq <= 1'b1;
      else if (h_iclr) ovf_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 frm <= '0;
    else if (fe_clr)            frm <= '0;
    else if (h_start && !wblk)  frm <= host_wdata[FRM_W-1:0];
    else if (eof && !hold)      frm <= (frm == last_frm) ? start_frm : frm + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_off <= '0;
      full     <= 1'b0;
    end else if (fe_clr || eof) begin
      main_off <= '0;
      full     <= 1'b0;
    end else if (h_pre) begin
      main_off <= (host_wdata > MAIN_LAST) ? MAIN_LAST : host_wdata;
      full     <= 1'b0;
    end else if (w_main) begin
      if (main_off == MAIN_LAST) full <= 1'b1;
      else                       main_off <= main_off + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_off <= Q_BASE;
      s_off <= S_BASE;
      e_off <= E_BASE;
    end else begin
      if (fe_clr || eof || qs_clr)     q_off <= Q_BASE;
      else if (w_q && q_off != Q_LAST) q_off <= q_off + 1'b1;
      if (fe_clr || eof || qs_clr)     s_off <= S_BASE;
      else if (w_s && s_off != S_LAST) s_off <= s_off + 1'b1;
      if (fe_clr || eof)               e_off <= E_BASE;
      else if (w_e && e_off != E_LAST) e_off <= e_off + 1'b1;
    end
  end

  a_r4_main_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    main_off <= MAIN_LAST);
  a_r3_q_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && wr_type == 3'd1) |-> (ram_addr[OFF_W-1:0] >= Q_BASE && ram_addr[OFF_W-1:0] <= Q_LAST));
  a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !h_iclr) |=> ovf_irq);
  a_r5_eof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !h_pre) |=> main_off == '0);
  a_r9_repeat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && hold && !fe_clr && !h_start) |=> $stable(frm));
  a_r6_wrap_start: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !hold && frm == last_frm && !fe_clr && !h_start) |=> frm == $past(start_frm));
endmodule

// File: tb/tb_fb_wr_addr_gen.sv
module tb_fb_wr_addr_gen;
  logic clk = 0, rst_n = 0;
  logic wr_stb = 0, host_we = 0, qs_clr = 0, fe_clr = 0;
  logic [2:0] wr_type = 0, host_addr = 0;
  logic [7:0] wr_data = 0;
  logic [11:0] host_wdata = 0;
  logic ram_we, ovf_irq;
  logic [22:0] ram_addr;
  logic [7:0] ram_wdata;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  fb_wr_addr_gen dut (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_type(wr_type),
    .wr_data(wr_data), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .qs_clr(qs_clr), .fe_clr(fe_clr), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ovf_irq(ovf_irq));

  logic [10:0] m_frm, m_start, m_last;
  logic [11:0] m_main, m_q, m_s, m_e;
  logic [7:0]  m_rep;
  logic m_wblk, m_repen, m_full, m_irq;

  task automatic model_reset();
    m_frm = 0; m_start = 0; m_last = 0; m_main = 0; m_q = 12'h930; m_s = 12'h940;
    m_e = 12'h9A0; m_rep = 0; m_wblk = 0; m_repen = 0; m_full = 0; m_irq = 0;
  endtask

  function automatic logic [22:0] exp_addr(input logic [2:0] t);
    case (t)
      3'd0: return {m_frm, m_main};
      3'd1: return {m_frm, m_q};
      3'd2: return {m_frm, m_s};
      3'd3: return {m_frm, m_e};
      default: return {m_frm, 12'hBDE};
    endcase
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic stb, input logic [2:0] t, input logic [7:0] d,
                      input logic hwe, input logic [2:0] ha, input logic [11:0] hd,
                      input logic qs, input logic sw);
    logic ew, eofm, hold, mw;
    logic [10:0] nf; logic [11:0] nm; logic nfull;
    @(negedge clk);
    wr_stb = stb; wr_type = t; wr_data = d; host_we = hwe; host_addr = ha;
    host_wdata = hd; qs_clr = qs; fe_clr = sw;
    #1;
    ew = stb && t <= 3'd4;
    if (ew) check(tag, ram_we && ram_addr == exp_addr(t) && ram_wdata == d,
                  {8'(ram_we), ram_addr}, {8'd1, exp_addr(t)});
    else    check(tag, !ram_we, 32'(ram_we), 32'd0);
    check("R4", ovf_irq == m_irq, 32'(ovf_irq), 32'(m_irq));
    @(posedge clk);
    eofm = stb && t == 3'd4;
    mw   = stb && t == 3'd0;
    hold = m_repen && m_rep != 0;
    nf = m_frm;
    if (sw) nf = 0;
    else if (hwe && ha == 0 && !m_wblk) nf = hd[10:0];
    else if (eofm && !hold) nf = (m_frm == m_last) ? m_start : m_frm + 1;
    nm = m_main; nfull = m_full;
    if (sw || eofm) begin nm = 0; nfull = 0; end
    else if (hwe && ha == 2) begin nm = (hd > 12'h92F) ? 12'h92F : hd; nfull = 0; end
    else if (mw) begin if (m_main == 12'h92F) nfull = 1; else nm = m_main + 1; end
    if (mw && m_full) m_irq = 1;
    else if (hwe && ha == 5 && hd[0]) m_irq = 0;
    if (sw || eofm || qs) begin m_q = 12'h930; m_s = 12'h940; end
    else begin
      if (stb && t == 1 && m_q != 12'h93F) m_q++;
      if (stb && t == 2 && m_s != 12'h99F) m_s++;
    end
    if (sw || eofm) m_e = 12'h9A0;
    else if (stb && t == 3 && m_e != 12'hAC5) m_e++;
    if (hwe && ha == 4) m_rep = hd[7:0];
    else if (eofm && hold) m_rep--;
    if (hwe && ha == 0) m_start = hd[10:0];
    if (hwe && ha == 1) m_last = hd[10:0];
    if (hwe && ha == 3) {m_repen, m_wblk} = hd[1:0];
    m_frm = nf; m_main = nm; m_full = nfull;
  endtask

  task automatic wr(input string tag, input logic [2:0] t, input logic [7:0] d);
    step(tag, 1, t, d, 0, 0, 0, 0, 0);
  endtask
  task automatic hw(input string tag, input logic [2:0] a, input logic [11:0] v);
    step(tag, 0, 0, 0, 1, a, v, 0, 0);
  endtask

  task automatic run_tests();
    int r;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check("R10", !ram_we && !ovf_irq, {ram_we, ovf_irq}, 0);
    wr("R10", 0, 8'hA5);
    wr("R1", 0, 8'h3C);
    hw("R7", 0, 12'd2);
    #1 wr("R7", 0, 8'h11);
    check("R7", ram_addr[22:12] == 11'd2, ram_addr[22:12], 2);
    hw("R7", 3, 12'd1);
    hw("R7", 0, 12'd5);
    wr("R7", 0, 8'h12);
    hw("R6", 1, 12'd3);
    wr("R5", 4, 8'hE0);
    wr("R5", 0, 8'h13);
    wr("R6", 4, 8'hE1);
    wr("R6", 0, 8'h14);
    check("R6", ram_addr == {11'd5, 12'h000}, ram_addr, {11'd5, 12'h000});
    hw("R7", 3, 12'd0);
    for (int i = 5; i < 8; i++) wr("R2", 3'(i), 8'h55);
    wr("R2", 0, 8'h15);
    for (int i = 0; i < 18; i++) wr("R3", 1, 8'(i));
    for (int i = 0; i < 3; i++) begin wr("R3", 2, 8'h20); wr("R3", 3, 8'h30); end
    step("R10", 0, 0, 0, 0, 0, 0, 1, 0);
    wr("R10", 1, 8'h40);
    wr("R10", 3, 8'h41);
    hw("R8", 2, 12'hFFF);
    wr("R8", 0, 8'h50);
    hw("R8", 2, 12'h92E);
    for (int i = 0; i < 3; i++) wr("R4", 0, 8'h60);
    hw("R4", 5, 12'd1);
    wr("R4", 0, 8'h61);
    step("R4", 1, 0, 8'h62, 1, 5, 12'd1, 0, 0);
    hw("R4", 5, 12'd1);
    hw("R9", 3, 12'd2);
    hw("R9", 4, 12'd2);
    for (int i = 0; i < 3; i++) begin wr("R9", 0, 8'h70); wr("R9", 4, 8'h71); end
    wr("R9", 0, 8'h72);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    wr("R10", 0, 8'h80);
    void'($urandom(32'd2024));
    for (int k = 0; k < 20000; k++) begin
      r = $urandom_range(0, 99);
      if (r < 55)      wr("R1", 0, 8'($urandom));
      else if (r < 62) wr("R3", 1, 8'($urandom));
      else if (r < 68) wr("R3", 2, 8'($urandom));
      else if (r < 74) wr("R3", 3, 8'($urandom));
      else if (r < 77) wr("R2", 3'($urandom_range(5, 7)), 8'($urandom));
      else if (r < 80) wr("R5", 4, 8'($urandom));
      else if (r < 82) hw("R7", 0, 12'($urandom_range(0, 7)));
      else if (r < 83) hw("R6", 1, 12'($urandom_range(0, 7)));
      else if (r < 85) hw("R8", 2, 12'($urandom_range(12'h900, 12'hA00)));
      else if (r < 86) hw("R9", 3, 12'($urandom_range(0, 3)));
      else if (r < 87) hw("R9", 4, 12'($urandom_range(0, 3)));
      else if (r < 89) hw("R4", 5, 12'($urandom_range(0, 1)));
      else if (r < 90) step("R10", 0, 0, 0, 0, 0, 0, 1, 0);
      else if (r < 91) step("R10", 0, 0, 0, 0, 0, 0, 0, 1);
      else             step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule